// File: doc/BRIEF.md
# Fixed-Point Arrival Timestamp Clock

This block keeps a running time-of-day value in 32.32 binary fixed point. The upper word counts whole seconds since the start of 1970, and the lower word holds the binary fraction of the current second. With this format, the interval between two arrivals is a single 64-bit subtraction. The fraction advances on ticks that a 32-bit phase accumulator derives from the local oscillator. The accumulator adds a programmable increment on every oscillator cycle. Each carry out of it is one tick. With a nominal 50 MHz oscillator and a suitable increment, the tick rate is a power of two such as 2^24 Hz.

Each tick adds 2^(32-TICK_LOG2) to the fraction. The fraction bits below that step are held at zero, so a reader interprets the value the same way whatever the tick rate is. When the fraction overflows, the seconds word increments.

Frame logic raises a snapshot request at packet arrival. The block then latches the whole 64-bit value from one cycle and presents it as a little-endian byte image. Software can set the seconds word through a load input. An optional pulse-per-second input, when enabled, aligns the time to the next whole second on its rising edge.

Top module: `arrival_ts_clock`

## Requirements
- R1: While reset is high, and on the first cycle after reset, ts_now, snap_le and snap_valid are all zero. The accumulator also starts from zero.
- R2: On every clock edge without a load or an accepted pulse, the accumulator adds phase_inc modulo 2^32, and a carry out of bit 31 is one tick. After n edges at a constant increment from a cleared accumulator, the number of ticks equals floor(n*phase_inc/2^32).
- R3: Each tick adds 2^(32-TICK_LOG2) to the fraction (ts_now[31:0]). The low 32-TICK_LOG2 bits of the fraction are always zero.
- R4: A fraction overflow increments the seconds word (ts_now[63:32]) on the same edge, and the seconds word wraps modulo 2^32. Without a load or a pulse, the seconds word changes by 0 or 1 per edge.
- R5: When sec_load is high at an edge, the seconds word becomes sec_load_val, and the fraction and the accumulator are cleared. A load takes priority over a tick and over a pulse in the same cycle.
- R6: When snap_req is high at an edge, snap_le on the next cycle equals the ts_now value seen before that edge. This holds also when a tick carries into the seconds word at that edge. snap_valid is high on exactly the cycles that follow a request cycle.
- R7: snap_le is a little-endian byte image: bits [8k+7:8k] hold byte k. Byte 0 is the least significant byte of the fraction, and bytes 4 to 7 hold the seconds word, with byte 4 being its least significant byte. The image holds its value until the next request.
- R8: With pps_en high, a rising edge of pps_in increments the seconds word and clears the fraction and the accumulator. The rising edge is pps_in high at an edge after it was low at the previous edge. Holding pps_in high has no further effect.
- R9: With pps_en low, pps_in has no effect on ts_now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_inc | input | ACC_W | Accumulator increment per clock |
| sec_load | input | 1 | Load seconds word, clear fraction and accumulator |
| sec_load_val | input | 32 | Seconds value to load |
| pps_en | input | 1 | Enable pulse alignment |
| pps_in | input | 1 | Pulse-per-second input |
| snap_req | input | 1 | Snapshot request from frame logic |
| ts_now | output | 64 | Running time, seconds in [63:32], fraction in [31:0] |
| snap_le | output | 64 | Latched timestamp, little-endian byte image |
| snap_valid | output | 1 | Snapshot updated on the previous edge |

## Verification
A snapshot request can land on the same edge as a tick that carries the fraction into the seconds word. This is the case where a non-atomic capture would pair a new seconds word with an old fraction.

The bench uses a reduced tick resolution and sweeps increments that tick every cycle, every other cycle and at irregular thirds. It also runs from seconds values next to the 32-bit wrap. Requests are issued on a fixed stride, so they fall on carry edges as well as on quiet edges. Each captured image is compared with a closed-form expected time for the request cycle, computed as floor(n*inc/2^32) ticks from the last clear.

The bench also drives a load and a pulse into the same cycle as a pending tick, and into the same cycle as each other. The pass criterion is the load-first priority order.

// File: rtl/ats_pkg.sv
package ats_pkg;

    localparam int SEC_W    = 32;
    localparam int FRAC_W   = 32;
    localparam int TS_W     = SEC_W + FRAC_W;
    localparam int BYTE_W   = 8;
    localparam int TS_BYTES = TS_W / BYTE_W;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_TICK  = 2'd1,
        UPD_PULSE = 2'd2,
        UPD_LOAD  = 2'd3
    } upd_e;

    // Priority: load, then pulse alignment, then an ordinary tick.
    function automatic upd_e pick_update(logic load, logic pulse, logic tick);
        if (load)       return UPD_LOAD;
        else if (pulse) return UPD_PULSE;
        else if (tick)  return UPD_TICK;
        else            return UPD_HOLD;
    endfunction

    // Byte k of the stored image carries bits [8k+7:8k] of the value.
    function automatic logic [TS_W-1:0] to_le_image(tod_t t);
        logic [TS_W-1:0] v;
        logic [TS_W-1:0] img;
        v   = t;
        img = '0;
        for (int k = 0; k < TS_BYTES; k++) begin
            img[k*BYTE_W +: BYTE_W] = v[k*BYTE_W +: BYTE_W];
        end
        return img;
    endfunction

endpackage

// File: rtl/ats_phase_acc.sv
module ats_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, inc};
    end

    assign tick = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/ats_tod.sv
module ats_tod
    import ats_pkg::*;
#(
    parameter int TICK_LOG2 = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_e             upd,
    input  logic [SEC_W-1:0] load_sec,
    output tod_t             tod
);

    localparam int RES_BITS = FRAC_W - TICK_LOG2;

    // Only the live fraction bits are stored; the rest are tied to zero.
    logic [SEC_W-1:0]     sec_q;
    logic [TICK_LOG2-1:0] cnt_q;
    logic [TICK_LOG2:0]   cnt_sum;

    always_comb begin
        cnt_sum = {1'b0, cnt_q} + {{TICK_LOG2{1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            cnt_q <= '0;
        end else begin
            case (upd)
                UPD_LOAD: begin
                    sec_q <= load_sec;
                    cnt_q <= '0;
                end
                UPD_PULSE: begin
                    sec_q <= sec_q + SEC_W'(1);
                    cnt_q <= '0;
                end
                UPD_TICK: begin
                    cnt_q <= cnt_sum[TICK_LOG2-1:0];
                    if (cnt_sum[TICK_LOG2]) begin
                        sec_q <= sec_q + SEC_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign tod.sec = sec_q;

    generate
        if (RES_BITS > 0) begin : g_coarse
            assign tod.frac = {cnt_q, {RES_BITS{1'b0}}};
        end else begin : g_full
            assign tod.frac = cnt_q;
        end
    endgenerate

endmodule

// File: rtl/ats_snap.sv
module ats_snap
    import ats_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  tod_t            tod_in,
    output logic [TS_W-1:0] snap_le,
    output logic            snap_valid
);

    logic [TS_W-1:0] img_q;
    logic            vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req;
            if (req) begin
                img_q <= to_le_image(tod_in);
            end
        end
    end

    assign snap_le    = img_q;
    assign snap_valid = vld_q;

endmodule

// File: rtl/arrival_ts_clock.sv
module arrival_ts_clock
    import ats_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int TICK_LOG2 = 24,
    parameter bit PPS_ALIGN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] phase_inc,
    input  logic             sec_load,
    input  logic [31:0]      sec_load_val,
    input  logic             pps_en,
    input  logic             pps_in,
    input  logic             snap_req,
    output logic [63:0]      ts_now,
    output logic [63:0]      snap_le,
    output logic             snap_valid
);

    initial begin
        if (TICK_LOG2 < 1 || TICK_LOG2 > FRAC_W) begin
            $error("TICK_LOG2 out of range");
        end
    end

    logic tick;
    logic pulse;
    logic acc_clear;
    upd_e upd;
    tod_t tod;

    generate
        if (PPS_ALIGN) begin : g_pps
            logic pps_q;
            always_ff @(posedge clk) begin
                pps_q <= pps_in;
            end
            assign pulse = pps_en & pps_in & ~pps_q;
        end else begin : g_no_pps
            assign pulse = 1'b0;
        end
    endgenerate

    assign acc_clear = sec_load | pulse;

    ats_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (acc_clear),
        .inc   (phase_inc),
        .tick  (tick)
    );

    always_comb begin
        upd = pick_update(sec_load, pulse, tick);
    end

    ats_tod #(.TICK_LOG2(TICK_LOG2)) u_tod (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .load_sec (sec_load_val),
        .tod      (tod)
    );

    ats_snap u_snap (
        .clk        (clk),
        .rst        (rst),
        .req        (snap_req),
        .tod_in     (tod),
        .snap_le    (snap_le),
        .snap_valid (snap_valid)
    );

    assign ts_now = tod;

endmodule

// File: rtl/arrival_ts_clock_chk.sv
module arrival_ts_clock_chk #(
    parameter int TICK_LOG2 = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        sec_load,
    input logic [31:0] sec_load_val,
    input logic        pps_en,
    input logic        pps_in,
    input logic        snap_req,
    input logic [63:0] ts_now,
    input logic [63:0] snap_le,
    input logic        snap_valid
);

    localparam logic [31:0] LOW_MASK =
        (TICK_LOG2 >= 32) ? 32'd0 : ((32'd1 << (32 - TICK_LOG2)) - 32'd1);

    // R3
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (ts_now[31:0] & LOW_MASK) == 32'd0);

    // R4
    a_r4_sec_step: assert property (@(posedge clk) disable iff (rst)
        (!sec_load && !(pps_en && $rose(pps_in)))
        |=> ((ts_now[63:32] - $past(ts_now[63:32])) <= 32'd1));

    // R5
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        sec_load |=> (ts_now == {$past(sec_load_val), 32'd0}));

    // R6
    a_r6_snap_valid: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> snap_valid);

    // R6
    a_r6_snap_quiet: assert property (@(posedge clk) disable iff (rst)
        !snap_req |=> !snap_valid);

    // R6
    a_r6_snap_atomic: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> (snap_le == $past(ts_now)));

    // R7
    a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !snap_req |=> $stable(snap_le));

    // R8
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        (pps_en && $rose(pps_in) && !sec_load)
        |=> (ts_now == {$past(ts_now[63:32]) + 32'd1, 32'd0}));

endmodule

bind arrival_ts_clock arrival_ts_clock_chk #(.TICK_LOG2(TICK_LOG2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sec_load     (sec_load),
    .sec_load_val (sec_load_val),
    .pps_en       (pps_en),
    .pps_in       (pps_in),
    .snap_req     (snap_req),
    .ts_now       (ts_now),
    .snap_le      (snap_le),
    .snap_valid   (snap_valid)
);

// File: tb/arrival_ts_clock_test.sv
module arrival_ts_clock_test;

    localparam int CLK_PERIOD = 10;
    localparam int TL         = 4;
    localparam int STEP_LOG2  = 32 - TL;
    localparam logic [63:0] LOW_MASK = (64'd1 << STEP_LOG2) - 64'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] phase_inc = 32'd0;
    logic        sec_load = 1'b0;
    logic [31:0] sec_load_val = 32'd0;
    logic        pps_en = 1'b0;
    logic        pps_in = 1'b0;
    logic        snap_req = 1'b0;
    logic [63:0] ts_now;
    logic [63:0] snap_le;
    logic        snap_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0]     base    = 32'd0;
    logic [31:0]     inc_cur = 32'd0;
    longint unsigned n       = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arrival_ts_clock #(.ACC_W(32), .TICK_LOG2(TL), .PPS_ALIGN(1'b1)) uut (
        .clk          (clk),
        .rst          (rst),
        .phase_inc    (phase_inc),
        .sec_load     (sec_load),
        .sec_load_val (sec_load_val),
        .pps_en       (pps_en),
        .pps_in       (pps_in),
        .snap_req     (snap_req),
        .ts_now       (ts_now),
        .snap_le      (snap_le),
        .snap_valid   (snap_valid)
    );

    function automatic logic [63:0] model(logic [31:0] b, longint unsigned cyc, logic [31:0] inc);
        longint unsigned prod;
        longint unsigned ticks;
        logic [63:0] total;
        prod  = cyc * longint'(inc);
        ticks = prod >> 32;
        total = 64'(ticks) << STEP_LOG2;
        return {b + total[63:32], total[31:0]};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a negative edge.
    task automatic run(int cycles, int snap_every);
        logic [63:0] exp;
        logic [63:0] pend;
        bit          have;
        for (int i = 0; i < cycles; i++) begin
            exp = model(base, n, inc_cur);
            check("R2/R4 ts_now", ts_now, exp);
            check("R3 low bits", ts_now & LOW_MASK, 64'd0);
            have = (snap_every > 0) && ((i % snap_every) == 0);
            snap_req = have;
            pend = exp;
            @(posedge clk);
            n++;
            @(negedge clk);
            snap_req = 1'b0;
            if (have) begin
                check("R6 snap_valid", 64'(snap_valid), 64'd1);
                check("R6 snap atomic", snap_le, pend);
                check("R7 byte4 sec lsb", 64'(snap_le[39:32]), 64'(pend[39:32]));
                check("R7 byte0 frac lsb", 64'(snap_le[7:0]), 64'(pend[7:0]));
            end else begin
                check("R6 snap_valid idle", 64'(snap_valid), 64'd0);
            end
        end
    endtask

    task automatic do_load(logic [31:0] val, logic [31:0] inc);
        sec_load     = 1'b1;
        sec_load_val = val;
        phase_inc    = inc;
        @(posedge clk);
        base    = val;
        inc_cur = inc;
        n       = 0;
        @(negedge clk);
        sec_load = 1'b0;
        check("R5 load", ts_now, {val, 32'd0});
    endtask

    // Raises pps_in at this edge; optionally with a load in the same cycle.
    task automatic pulse_edge(bit with_load, logic [31:0] val);
        logic [63:0] exp;
        exp    = model(base, n, inc_cur);
        pps_in = 1'b1;
        if (with_load) begin
            sec_load     = 1'b1;
            sec_load_val = val;
        end
        @(posedge clk);
        if (with_load) begin
            base = val;
            n    = 0;
        end else if (pps_en) begin
            base = exp[63:32] + 32'd1;
            n    = 0;
        end else begin
            n++;
        end
        @(negedge clk);
        sec_load = 1'b0;
        if (with_load)
            check("R5 load over pulse", ts_now, {val, 32'd0});
        else if (pps_en)
            check("R8 pulse align", ts_now, {exp[63:32] + 32'd1, 32'd0});
        else
            check("R9 pulse ignored", ts_now, model(base, n, inc_cur));
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ts_now", ts_now, 64'd0);
        check("R1 reset snap_le", snap_le, 64'd0);
        check("R1 reset snap_valid", 64'(snap_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", ts_now, 64'd0);
        check("R1 after reset valid", 64'(snap_valid), 64'd0);

        // Sweep of increments, snapshots on strides landing on carry edges.
        do_load(32'd100, 32'h8000_0000);
        run(70, 3);
        do_load(32'd7, 32'h5555_5555);
        run(120, 5);
        do_load(32'd9, 32'hFFFF_FFFF);
        run(60, 2);
        do_load(32'd1, 32'h1000_0000);
        run(300, 7);
        do_load(32'd3, 32'd0);
        run(20, 4);

        // Seconds wrap near the 32-bit limit.
        do_load(32'hFFFF_FFFE, 32'h8000_0000);
        run(90, 1);

        // Load while a tick is pending every cycle.
        do_load(32'd50, 32'hFFFF_FFFF);
        run(5, 0);
        do_load(32'd60, 32'hFFFF_FFFF);
        run(10, 3);

        // Pulse alignment, held level, then disabled.
        pps_en = 1'b1;
        run(9, 0);
        pulse_edge(1'b0, 32'd0);
        run(12, 4);
        pps_in = 1'b0;
        run(5, 0);
        pulse_edge(1'b0, 32'd0);
        run(4, 0);
        pps_in = 1'b0;
        run(3, 0);
        pulse_edge(1'b1, 32'd777);
        run(10, 2);
        pps_in = 1'b0;
        pps_en = 1'b0;
        run(4, 0);
        pulse_edge(1'b0, 32'd0);
        run(10, 3);
        pps_in = 1'b0;
        run(5, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule